// File: doc/BRIEF.md
# Oversampled Serial Receive Engine

This block recovers characters from an asynchronous serial line. The line is sampled on a strobe that runs at sixteen times the bit rate. A falling level starts a frame. The start bit is confirmed at its centre, and each later bit is taken at its centre. Characters of five to eight data bits are assembled least significant bit first. An optional parity bit is checked, then the first stop bit.

A finished character is placed in a single-entry holding buffer, and a request flag shows that the buffer is occupied. Four sticky condition flags report problems: a line break, a missing stop bit, a parity mismatch and a lost character. A status-read strobe clears all four. A data-read strobe empties the buffer. A separate acknowledge strobe drops the request flag without discarding the character.

The configuration byte uses the same field layout that a companion transmitter decodes, so one byte can drive both directions.

Top module: `uart_rx_engine`

## Requirements
- R1: A frame starts only when the line is low on a sample strobe while the engine is idle, and stays low on the eighth strobe after that. A low pulse that is high again by the eighth strobe produces no character.
- R2: Each data, parity and stop bit is sampled sixteen strobes after the previous sample. The first bit after the start bit lands in data bit 0.
- R3: Configuration bits [1:0] select the character length (00=5, 01=6, 10=7, 11=8 bits). Data bits at or above the selected length read as zero.
- R4: Configuration bits [5:3] select the parity mode: bit 3 set enables parity. 001 is odd, 011 is even, 101 expects a 1 and 111 expects a 0. Any value with bit 3 clear means no parity bit. A received parity bit that differs from the expected value sets the parity flag.
- R5: A low first stop bit sets the framing flag.
- R6: When all data bits, the parity bit (if any) and the stop bit sample low, the break flag and the framing flag are set and a zero character is stored. No new frame starts until the line has returned high.
- R7: A completed character sets the full flag and appears on the data output. The data-read strobe clears the full flag.
- R8: The acknowledge strobe clears the full flag and leaves the data output unchanged.
- R9: A character that completes while the full flag is set (and no read or acknowledge happens in that cycle) sets the overrun flag. The buffered character is kept.
- R10: The break, framing, parity and overrun flags stay set until the status-read strobe, which clears all four.
- R11: Configuration bits [2] and [7:6] have no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_byte | input | 8 | Line configuration: length [1:0], parity mode [5:3] |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| data_rd | input | 1 | Data-read strobe; empties the buffer |
| status_rd | input | 1 | Status-read strobe; clears the four condition flags |
| req_ack | input | 1 | Acknowledge strobe; clears the full flag only |
| rx_data | output | 8 | Buffered character, zero-filled above its length |
| rx_full | output | 1 | Buffer holds an unread character |
| brk_det | output | 1 | Sticky break flag |
| frame_err | output | 1 | Sticky framing flag |
| parity_err | output | 1 | Sticky parity flag |
| overrun_err | output | 1 | Sticky overrun flag |

## Verification
The assertions check the buffer and flag bookkeeping on every cycle:
- zero-filling of the stored character for the configured length;
- the full flag holding until a read or an acknowledge;
- clearing on a status read;
- keeping the old character on overrun;
- a break always arriving together with a framing error.

Only the bench's scenarios can show the serial side: glitch rejection at mid-bit, bit order and spacing, the expected parity in each of the four modes, and refusing a new frame while a break is still held.

// File: rtl/uart_rx_pkg.sv
// Shared types and helpers for the serial receive engine.
// Assumes a fixed 8-bit data path; character lengths are 5..8 bits.
package uart_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic brk;
        logic frame;
        logic parity;
    } frame_err_t;

    // Expected parity bit for a zero-filled character under mode pm.
    function automatic logic parity_expect(input logic [DATA_W-1:0] d,
                                           input logic [2:0] pm);
        logic r;
        if (pm[2]) r = ~pm[1];
        else if (pm[1]) r = ^d;
        else r = ~^d;
        return r;
    endfunction

endpackage

// File: rtl/rx_sync.sv
// Multi-stage synchronizer for the asynchronous serial input.
// Resets to the idle (high) level so no false start is seen after reset.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First flop captures the raw line.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Later flops resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
// Frame sequencer. It finds the start bit, samples each bit at its centre
// using the oversample strobe, and assembles a zero-filled character.
// After the stop sample it reports the character and its errors with a
// one-cycle pulse. Assumes the configuration is stable during a frame.
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              tick,
    input  logic [1:0]        len_code,
    input  logic [2:0]        par_mode,
    output logic              done,
    output logic [DATA_W-1:0] char_out,
    output frame_err_t        err_out
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] MID_LAST  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(OVERSAMPLE - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              par_en;
    logic [2:0]        last_idx;
    logic              exp_par;
    logic              at_full;

    // Decode the length and parity fields for this frame.
    always_comb begin
        par_en   = par_mode[0];
        last_idx = {1'b1, len_code};
        exp_par  = parity_expect(shreg, par_mode);
        at_full  = tick && (cnt == FULL_LAST);
    end

    // Sequencer, bit counters and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            done     <= 1'b0;
            char_out <= '0;
            err_out  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tick && !rx_bit) begin
                        state   <= ST_START;
                        cnt     <= '0;
                        shreg   <= '0;
                        par_bit <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (cnt == MID_LAST) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                            state   <= rx_bit ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (at_full) begin
                        cnt            <= '0;
                        shreg[bit_idx] <= rx_bit;
                        if (bit_idx == last_idx)
                            state <= par_en ? ST_PARITY : ST_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (at_full) begin
                        cnt     <= '0;
                        par_bit <= rx_bit;
                        state   <= ST_STOP;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_full) begin
                        cnt            <= '0;
                        done           <= 1'b1;
                        char_out       <= shreg;
                        err_out.frame  <= !rx_bit;
                        err_out.parity <= par_en && (par_bit != exp_par);
                        err_out.brk    <= !rx_bit && (shreg == '0) &&
                                          !(par_en && par_bit);
                        state          <= rx_bit ? ST_IDLE : ST_HOLD;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (rx_bit) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_status_regs.sv
// One-entry character buffer with full flag and sticky condition flags.
// A read or acknowledge in the same cycle as a completion frees the slot,
// and the new character is stored. A flag set in the same cycle as a
// status read stays set.
module rx_status_regs
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] char_in,
    input  frame_err_t        err_in,
    input  logic              data_rd,
    input  logic              status_rd,
    input  logic              req_ack,
    output logic [DATA_W-1:0] buf_data,
    output logic              full,
    output logic              brk,
    output logic              fe,
    output logic              pe,
    output logic              oe
);
    logic slot_free;
    logic lost;

    // Decide whether a completed character can be accepted.
    always_comb begin
        slot_free = !full || data_rd || req_ack;
        lost      = done && !slot_free;
    end

    // Buffer contents and full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_data <= '0;
            full     <= 1'b0;
        end else if (done && slot_free) begin
            buf_data <= char_in;
            full     <= 1'b1;
        end else if (data_rd || req_ack) begin
            full <= 1'b0;
        end
    end

    // Sticky flags, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk <= 1'b0;
            fe  <= 1'b0;
            pe  <= 1'b0;
            oe  <= 1'b0;
        end else begin
            brk <= (brk && !status_rd) || (done && err_in.brk);
            fe  <= (fe  && !status_rd) || (done && err_in.frame);
            pe  <= (pe  && !status_rd) || (done && err_in.parity);
            oe  <= (oe  && !status_rd) || lost;
        end
    end
endmodule

// File: rtl/uart_rx_engine.sv
// Top of the serial receive engine: a synchronizer, then the frame
// sequencer, then the buffer and flags. Config fields: [1:0] length,
// [5:3] parity mode. Bits [2] and [7:6] are not used for reception.
module uart_rx_engine
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic [7:0]        cfg_byte,
    input  logic              os_tick,
    input  logic              data_rd,
    input  logic              status_rd,
    input  logic              req_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              brk_det,
    output logic              frame_err,
    output logic              parity_err,
    output logic              overrun_err
);
    logic              rx_s;
    logic              frm_done;
    logic [DATA_W-1:0] frm_char;
    frame_err_t        frm_err;
    logic              unused_cfg;

    assign unused_cfg = ^{cfg_byte[7:6], cfg_byte[2]};

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_line),
        .q_sync  (rx_s)
    );

    rx_frame_fsm #(.OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_bit   (rx_s),
        .tick     (os_tick),
        .len_code (cfg_byte[1:0]),
        .par_mode (cfg_byte[5:3]),
        .done     (frm_done),
        .char_out (frm_char),
        .err_out  (frm_err)
    );

    rx_status_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (frm_done),
        .char_in   (frm_char),
        .err_in    (frm_err),
        .data_rd   (data_rd),
        .status_rd (status_rd),
        .req_ack   (req_ack),
        .buf_data  (rx_data),
        .full      (rx_full),
        .brk       (brk_det),
        .fe        (frame_err),
        .pe        (parity_err),
        .oe        (overrun_err)
    );
endmodule

// File: rtl/rx_engine_chk.sv
// Property checker for the receive engine, attached to the top by bind.
// It watches the buffer and flag behaviour against the completion pulse.
module rx_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_byte,
    input logic       data_rd,
    input logic       status_rd,
    input logic       req_ack,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       brk_det,
    input logic       frame_err,
    input logic       parity_err,
    input logic       overrun_err,
    input logic       frm_done
);
    logic [7:0] keep_mask;
    assign keep_mask = 8'hFF >> (2'd3 - cfg_byte[1:0]);

    // R3: stored character has no bits above the configured length
    a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> ((rx_data & ~keep_mask) == 8'h00));

    // R7: full flag holds until a read or acknowledge
    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !data_rd && !req_ack |=> rx_full);

    // R7: a read with no completion empties the buffer
    a_r7_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !frm_done |=> !rx_full);

    // R8: acknowledge drops the flag and keeps the character
    a_r8_ack_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack && !frm_done |=> !rx_full && $stable(rx_data));

    // R9: completion into a full buffer flags overrun and keeps old data
    a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && rx_full && !data_rd && !req_ack |=> overrun_err && $stable(rx_data));

    // R6: a break is always reported together with a framing error
    a_r6_break_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_det) |-> frame_err);

    // R10: status read with no completion clears all four flags
    a_r10_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd && !frm_done |=> !brk_det && !frame_err && !parity_err && !overrun_err);

    // R10: flags are sticky without a status read
    a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err || overrun_err) && !status_rd |=>
            ($past(parity_err) -> parity_err) && ($past(overrun_err) -> overrun_err));
endmodule

bind uart_rx_engine rx_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_byte    (cfg_byte),
    .data_rd     (data_rd),
    .status_rd   (status_rd),
    .req_ack     (req_ack),
    .rx_data     (rx_data),
    .rx_full     (rx_full),
    .brk_det     (brk_det),
    .frame_err   (frame_err),
    .parity_err  (parity_err),
    .overrun_err (overrun_err),
    .frm_done    (frm_done)
);

// File: tb/sim_uart_rx_engine.sv
// Bench for the serial receive engine: a vector table walked by one loop,
// then directed tests for reset, glitch, break, overrun and acknowledge.
module sim_uart_rx_engine;
    localparam int BIT_CLKS = 64;   // 16 strobes x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] cfg_byte = 8'h03;
    logic       os_tick = 1'b0;
    logic       data_rd = 1'b0;
    logic       status_rd = 1'b0;
    logic       req_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, brk_det, frame_err, parity_err, overrun_err;

    int checks = 0;
    int errors = 0;

    // {cfg, data, flip parity, stop low}
    localparam logic [17:0] VEC [10] = '{
        {8'h03, 8'hA5, 1'b0, 1'b0},
        {8'h00, 8'hFF, 1'b0, 1'b0},
        {8'h09, 8'h2A, 1'b0, 1'b0},
        {8'h1A, 8'h55, 1'b0, 1'b0},
        {8'h2B, 8'h81, 1'b0, 1'b0},
        {8'h3B, 8'h7E, 1'b0, 1'b0},
        {8'h0B, 8'h3C, 1'b1, 1'b0},
        {8'h03, 8'hC3, 1'b0, 1'b1},
        {8'h18, 8'h13, 1'b1, 1'b0},
        {8'hC7, 8'h96, 1'b0, 1'b0}
    };

    uart_rx_engine u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .cfg_byte(cfg_byte),
        .os_tick(os_tick), .data_rd(data_rd), .status_rd(status_rd),
        .req_ack(req_ack), .rx_data(rx_data), .rx_full(rx_full),
        .brk_det(brk_det), .frame_err(frame_err), .parity_err(parity_err),
        .overrun_err(overrun_err)
    );

    always #2 clk = ~clk;

    // Oversample strobe: one clock in four.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] len_mask(input logic [1:0] lc);
        return 8'hFF >> (3 - lc);
    endfunction

    function automatic logic model_par(input logic [7:0] cfg, input logic [7:0] d);
        logic [7:0] m;
        m = d & len_mask(cfg[1:0]);
        if (cfg[5]) return !cfg[4];
        if (cfg[4]) return ^m;
        return ~^m;
    endfunction

    task automatic drive_bit(input logic b);
        rx_line = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] cfg, input logic [7:0] d,
                              input logic flip, input logic stop_low);
        cfg_byte = cfg;
        drive_bit(1'b0);
        for (int i = 0; i < 5 + int'(cfg[1:0]); i++) drive_bit(d[i]);
        if (cfg[3]) drive_bit(model_par(cfg, d) ^ flip);
        drive_bit(!stop_low);
        drive_bit(1'b1);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] c, d;
        logic fl, sl;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R7 reset full", {7'd0, rx_full}, 8'h00);
        chk("R10 reset flags", {4'd0, brk_det, frame_err, parity_err, overrun_err}, 8'h00);
        chk("R7 reset data", rx_data, 8'h00);

        // R1: short low glitch must not start a frame
        rx_line = 1'b0;
        repeat (16) @(negedge clk);
        rx_line = 1'b1;
        repeat (20 * BIT_CLKS) @(negedge clk);
        chk("R1 glitch rejected full", {7'd0, rx_full}, 8'h00);
        chk("R1 glitch rejected flags", {4'd0, brk_det, frame_err, parity_err, overrun_err}, 8'h00);

        // Vector loop: R2 R3 R4 R5 R7 R10 R11
        foreach (VEC[k]) begin
            {c, d, fl, sl} = VEC[k];
            send_frame(c, d, fl, sl);
            chk("R2 R3 data", rx_data, d & len_mask(c[1:0]));
            chk("R7 full set", {7'd0, rx_full}, 8'h01);
            chk("R4 parity flag", {7'd0, parity_err}, {7'd0, fl & c[3]});
            chk("R5 framing flag", {7'd0, frame_err}, {7'd0, sl});
            chk("R11 no break/overrun", {6'd0, brk_det, overrun_err}, 8'h00);
            pulse(status_rd);
            chk("R10 status clears", {4'd0, brk_det, frame_err, parity_err, overrun_err}, 8'h00);
            pulse(data_rd);
            chk("R7 read empties", {7'd0, rx_full}, 8'h00);
        end

        // R6: break held low well past the frame
        cfg_byte = 8'h03;
        rx_line = 1'b0;
        repeat (20 * BIT_CLKS) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        chk("R6 break flag", {7'd0, brk_det}, 8'h01);
        chk("R6 framing with break", {7'd0, frame_err}, 8'h01);
        chk("R6 break data zero", rx_data, 8'h00);
        chk("R6 break full", {7'd0, rx_full}, 8'h01);
        pulse(status_rd);
        pulse(data_rd);
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R6 single char per break", {7'd0, rx_full}, 8'h00);
        chk("R10 break cleared", {7'd0, brk_det}, 8'h00);

        // R9: second character into full buffer
        send_frame(8'h03, 8'h11, 1'b0, 1'b0);
        send_frame(8'h03, 8'h22, 1'b0, 1'b0);
        chk("R9 overrun flag", {7'd0, overrun_err}, 8'h01);
        chk("R9 old char kept", rx_data, 8'h11);
        chk("R9 still full", {7'd0, rx_full}, 8'h01);
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R10 overrun sticky", {7'd0, overrun_err}, 8'h01);
        pulse(status_rd);
        chk("R10 overrun cleared", {7'd0, overrun_err}, 8'h00);
        pulse(data_rd);

        // R8: acknowledge keeps data and frees the slot
        send_frame(8'h03, 8'h5A, 1'b0, 1'b0);
        pulse(req_ack);
        chk("R8 ack clears full", {7'd0, rx_full}, 8'h00);
        chk("R8 ack keeps data", rx_data, 8'h5A);
        send_frame(8'h03, 8'hE7, 1'b0, 1'b0);
        chk("R8 no overrun after ack", {7'd0, overrun_err}, 8'h00);
        chk("R8 new char stored", rx_data, 8'hE7);
        pulse(data_rd);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule